// File: doc/BRIEF.md
# Serial Word Transmitter with Underrun Replay

This block sends fixed-width words, 16 bits by default, on a single serial data line. It sends one bit on each active edge of a bit clock. The bit clock comes from one of two places: an external clock pin, or the receive-side bit clock. The receive-side clock can optionally be divided by two. A control input picks whether the rising or the falling edge is the active one. Another control input picks whether a word goes out most-significant bit first or least-significant bit first.

Words arrive on a valid/ready word interface and wait in a single staging register. A frame starts only on an active edge at which the frame sync input is high. On that edge the staged word is loaded and its first bit is driven. If a reload is due and no new word is staged, the previous word is sent again and a sticky underrun flag is raised. Configuration inputs are expected to stay fixed while the transmitter is enabled.

The control sequencer has three states:
- `ST_IDLE`: disabled, with the line held low.
- `ST_WAIT_SYNC`: enabled and waiting for a synced edge.
- `ST_SHIFT`: sending a frame.

Its transitions are:
- enable: `ST_IDLE` to `ST_WAIT_SYNC`.
- sync-load: `ST_WAIT_SYNC` to `ST_SHIFT`, on an active edge with sync high.
- shift: `ST_SHIFT` to itself while bits remain.
- chain-load: `ST_SHIFT` to itself, on an active edge with sync high after the last bit.
- resync: `ST_SHIFT` to `ST_WAIT_SYNC`, on an active edge without sync after the last bit.
- disable: any state to `ST_IDLE` when the enable input is low.

Top module: `sertx_tx`

## Requirements
- R1: After reset `sdo` is 0, `urun_flag` is 0 and `word_ready` is 1.
- R2: While `tx_en` is low, `sdo` is driven 0 from the next clock on, and bit-clock edges have no effect.
- R3: With `lsb_first`=0, a frame drives bit WORD_W-1 of the word first, then the lower bits in descending order, one per active edge.
- R4: With `lsb_first`=1, a frame drives bit 0 first, then the higher bits in ascending order, one per active edge.
- R5: `fall_edge`=0 makes low-to-high transitions of the selected bit clock active, and `fall_edge`=1 makes high-to-low transitions active. An inactive transition does not change `sdo`.
- R6: `src_rcv`=0 selects `ext_bclk` as the bit clock and `src_rcv`=1 selects `rcv_bclk`. Transitions on the clock that is not selected do not change `sdo`.
- R7: With `src_rcv`=1 and `div2_en`=1, the bit clock is an internal divided clock. It toggles on every rising edge of `rcv_bclk` and is low after reset, so its first rise comes with the first `rcv_bclk` rise after reset.
- R8: In `ST_WAIT_SYNC`, active edges with `fsync` low start nothing. The first bit of a frame is driven on the first active edge at which `fsync` is high.
- R9: After the last bit of a frame, an active edge with `fsync` high loads the next word and drives its first bit. An active edge with `fsync` low returns to `ST_WAIT_SYNC` and `sdo` keeps the last bit.
- R10: If a load finds no staged word, the previously loaded word is sent again (all zeros if none was ever loaded) and `urun_flag` is set. A load that finds a staged word leaves the flag alone.
- R11: `urun_flag` stays set until `urun_clr` is high at a clock edge or reset is applied.
- R12: While enabled, `sdo` changes only on active edges of the bit clock.
- R13: The staging register holds one word. `word_ready` is 0 while it is full, so a word offered then is not taken, and it empties when a frame load takes the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset to power-up state |
| tx_en | input | 1 | Transmitter enable |
| ext_bclk | input | 1 | External bit clock level (already synchronous to clk) |
| rcv_bclk | input | 1 | Receive-side bit clock level (already synchronous to clk) |
| src_rcv | input | 1 | Bit clock source: 0 external pin, 1 receive clock |
| div2_en | input | 1 | Divide the receive clock by two when it is the source |
| fall_edge | input | 1 | Active edge: 0 rising, 1 falling |
| lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| fsync | input | 1 | Frame sync level, sampled at active edges |
| word_valid | input | 1 | A word is offered |
| word_data | input | WORD_W | Offered word |
| word_ready | output | 1 | Staging register is empty and can take a word |
| urun_clr | input | 1 | Clears the underrun flag |
| sdo | output | 1 | Serial data out |
| urun_flag | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with WORD_W=8 and the divider present. This word width lets it send every one of the 256 word values in both bit orders. The MSB-first sweep runs on rising edges of the external pin. The LSB-first sweep runs on falling edges of the receive clock. A shorter run then uses the divided receive clock. During these runs the bench toggles the unselected clock and drives inactive edges in mid-frame, resyncs after a frame with no sync, and forces underruns by withholding words. Its model counts every receive-clock rise since reset, so it knows the divider phase exactly. It also offers a second word while the staging register is full, and it checks that the line goes low on disable.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_SYNC = 2'd1,
        ST_SHIFT     = 2'd2
    } tx_state_t;

endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
    parameter bit HAS_DIV2 = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_bclk,
    input  logic rcv_bclk,
    input  logic src_rcv,
    input  logic div2_en,
    input  logic fall_edge,
    output logic bit_tick
);

    logic rcv_eff;
    logic sel_lvl;
    logic lvl_q;

    generate
        if (HAS_DIV2) begin : g_div
            logic rcv_q;
            logic half_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rcv_q  <= 1'b0;
                    half_q <= 1'b0;
                end else begin
                    rcv_q <= rcv_bclk;
                    if (rcv_bclk && !rcv_q) begin
                        half_q <= ~half_q;
                    end
                end
            end

            assign rcv_eff = div2_en ? half_q : rcv_bclk;
        end else begin : g_nodiv
            logic unused_div;
            assign unused_div = div2_en;
            assign rcv_eff    = rcv_bclk;
        end
    endgenerate

    assign sel_lvl = src_rcv ? rcv_eff : ext_bclk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= sel_lvl;
        end
    end

    // Active edge: level changed and the new level matches the chosen edge.
    assign bit_tick = (sel_lvl != lvl_q) && (sel_lvl == ~fall_edge);

endmodule

// File: rtl/sertx_stage.sv
module sertx_stage #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              take,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    logic              full_q;
    logic [WORD_W-1:0] data_q;

    assign in_ready  = !full_q;
    assign out_valid = full_q;
    assign out_data  = data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full_q <= 1'b0;
        end else if (in_valid && !full_q) begin
            full_q <= 1'b1;
            data_q <= in_data;
        end
    end

endmodule

// File: rtl/sertx_shift_fsm.sv
module sertx_shift_fsm
    import sertx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_tick,
    input  logic              fsync,
    input  logic              lsb_first,
    input  logic              stage_valid,
    input  logic [WORD_W-1:0] stage_data,
    output logic              stage_take,
    input  logic              urun_clr,
    output logic              sdo,
    output logic              urun_flag
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W);

    tx_state_t         state_q, state_d;
    logic              do_load;
    logic              do_shift;
    logic [WORD_W-1:0] load_word;
    logic [WORD_W-1:0] sr_q;
    logic [WORD_W-1:0] last_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sdo_q;
    logic              flag_q;

    // Next-state and action decode
    always_comb begin
        state_d  = state_q;
        do_load  = 1'b0;
        do_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_en) state_d = ST_WAIT_SYNC;
            end
            ST_WAIT_SYNC: begin
                if (!tx_en) begin
                    state_d = ST_IDLE;
                end else if (bit_tick && fsync) begin
                    do_load = 1'b1;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!tx_en) begin
                    state_d = ST_IDLE;
                end else if (bit_tick) begin
                    if (cnt_q < LAST_CNT) begin
                        do_shift = 1'b1;
                    end else if (fsync) begin
                        do_load = 1'b1;
                    end else begin
                        state_d = ST_WAIT_SYNC;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign stage_take = do_load && stage_valid;
    assign load_word  = stage_valid ? stage_data : last_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            last_q <= '0;
            cnt_q  <= '0;
            sdo_q  <= 1'b0;
        end else if (!tx_en) begin
            sdo_q <= 1'b0;
            cnt_q <= '0;
        end else if (do_load) begin
            last_q <= load_word;
            cnt_q  <= CNT_W'(1);
            if (lsb_first) begin
                sdo_q <= load_word[0];
                sr_q  <= load_word >> 1;
            end else begin
                sdo_q <= load_word[WORD_W-1];
                sr_q  <= load_word << 1;
            end
        end else if (do_shift) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (lsb_first) begin
                sdo_q <= sr_q[0];
                sr_q  <= sr_q >> 1;
            end else begin
                sdo_q <= sr_q[WORD_W-1];
                sr_q  <= sr_q << 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (do_load && !stage_valid) begin
            flag_q <= 1'b1;
        end else if (urun_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign sdo       = sdo_q;
    assign urun_flag = flag_q;

endmodule

// File: rtl/sertx_tx.sv
module sertx_tx #(
    parameter int WORD_W   = 16,
    parameter bit HAS_DIV2 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              ext_bclk,
    input  logic              rcv_bclk,
    input  logic              src_rcv,
    input  logic              div2_en,
    input  logic              fall_edge,
    input  logic              lsb_first,
    input  logic              fsync,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic              urun_clr,
    output logic              sdo,
    output logic              urun_flag
);

    logic              bit_tick;
    logic              stage_valid;
    logic [WORD_W-1:0] stage_data;
    logic              stage_take;

    sertx_bitclk #(
        .HAS_DIV2 (HAS_DIV2)
    ) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_bclk  (ext_bclk),
        .rcv_bclk  (rcv_bclk),
        .src_rcv   (src_rcv),
        .div2_en   (div2_en),
        .fall_edge (fall_edge),
        .bit_tick  (bit_tick)
    );

    sertx_stage #(
        .WORD_W (WORD_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (word_valid),
        .in_data   (word_data),
        .in_ready  (word_ready),
        .take      (stage_take),
        .out_valid (stage_valid),
        .out_data  (stage_data)
    );

    sertx_shift_fsm #(
        .WORD_W (WORD_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .bit_tick    (bit_tick),
        .fsync       (fsync),
        .lsb_first   (lsb_first),
        .stage_valid (stage_valid),
        .stage_data  (stage_data),
        .stage_take  (stage_take),
        .urun_clr    (urun_clr),
        .sdo         (sdo),
        .urun_flag   (urun_flag)
    );

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic bit_tick,
    input logic urun_clr,
    input logic word_ready,
    input logic sdo,
    input logic urun_flag
);

    // R2: disabled transmitter drives the line low
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !sdo);

    // R12: no active edge, no change on the line
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !bit_tick) |=> $stable(sdo));

    // R11: flag is sticky until cleared
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_flag && !urun_clr) |=> urun_flag);

    // R10: an underrun is only recorded at an active edge
    p_urun_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(urun_flag) |-> $past(bit_tick));

    // R13: a full staging register only drains at an active edge
    p_ready_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_ready && !bit_tick) |=> !word_ready);

endmodule

bind sertx_tx sertx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .bit_tick   (bit_tick),
    .urun_clr   (urun_clr),
    .word_ready (word_ready),
    .sdo        (sdo),
    .urun_flag  (urun_flag)
);

// File: tb/sertx_tx_tb.sv
module sertx_tx_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_en = 1'b0;
    logic         ext_l = 1'b0;
    logic         rcv_l = 1'b0;
    logic         src_rcv = 1'b0;
    logic         div2_en = 1'b0;
    logic         fall_edge = 1'b0;
    logic         lsb_first = 1'b0;
    logic         fsync = 1'b0;
    logic         word_valid = 1'b0;
    logic [W-1:0] word_data = '0;
    logic         word_ready;
    logic         urun_clr = 1'b0;
    logic         sdo;
    logic         urun_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int rcv_rises = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sertx_tx #(.WORD_W(W), .HAS_DIV2(1'b1)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .ext_bclk   (ext_l),
        .rcv_bclk   (rcv_l),
        .src_rcv    (src_rcv),
        .div2_en    (div2_en),
        .fall_edge  (fall_edge),
        .lsb_first  (lsb_first),
        .fsync      (fsync),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .urun_clr   (urun_clr),
        .sdo        (sdo),
        .urun_flag  (urun_flag)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ext(input logic v);
        ext_l = v;
        wait_cyc(4);
    endtask

    task automatic set_rcv(input logic v);
        if (v && !rcv_l) rcv_rises++;
        rcv_l = v;
        wait_cyc(4);
    endtask

    // Produce one active edge of the effective bit clock, per the bench's model.
    task automatic one_tick();
        logic tgt;
        bit   got;
        tgt = !fall_edge;
        if (src_rcv && div2_en) begin
            got = 1'b0;
            while (!got) begin
                if (rcv_l) set_rcv(1'b0);
                set_rcv(1'b1);
                got = ((rcv_rises % 2) == 1) != fall_edge;
            end
        end else if (src_rcv) begin
            if (rcv_l == tgt) set_rcv(!tgt);
            set_rcv(tgt);
        end else begin
            if (ext_l == tgt) set_ext(!tgt);
            set_ext(tgt);
        end
    endtask

    // Toggle the unselected clock and make an inactive edge on the selected one.
    task automatic disturb(input logic exp_bit);
        for (int k = 0; k < 3; k++) begin
            if (src_rcv) begin
                set_ext(!ext_l);
                set_ext(!ext_l);
            end else begin
                set_rcv(!rcv_l);
                set_rcv(!rcv_l);
            end
        end
        chk(sdo == exp_bit, "R6 unselected clock", sdo, exp_bit);
        if (!(src_rcv && div2_en)) begin
            if (src_rcv) set_rcv(fall_edge); else set_ext(fall_edge);
            chk(sdo == exp_bit, "R5 inactive edge", sdo, exp_bit);
        end
    endtask

    task automatic push(input logic [W-1:0] w);
        int guard;
        guard = 0;
        while (!word_ready && guard < 100) begin
            wait_cyc(1);
            guard++;
        end
        word_data  = w;
        word_valid = 1'b1;
        wait_cyc(1);
        word_valid = 1'b0;
    endtask

    function automatic logic exp_bit(input logic [W-1:0] w, input int i);
        return lsb_first ? w[i] : w[W-1-i];
    endfunction

    task automatic send_frame(input logic [W-1:0] w, input int disturb_at);
        for (int i = 0; i < W; i++) begin
            fsync = (i == 0);
            one_tick();
            fsync = 1'b0;
            chk(sdo == exp_bit(w, i), lsb_first ? "R4 bit order" : "R3 bit order",
                sdo, exp_bit(w, i));
            if (i == disturb_at) disturb(exp_bit(w, i));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        chk(sdo == 1'b0, "R1 sdo", sdo, 0);
        chk(urun_flag == 1'b0, "R1 flag", urun_flag, 0);
        chk(word_ready == 1'b1, "R1 ready", word_ready, 1);

        // MSB first, rising edges of the external pin
        tx_en = 1'b1;
        wait_cyc(2);
        one_tick();
        one_tick();
        chk(sdo == 1'b0, "R8 no start without sync", sdo, 0);
        for (int w = 0; w < 256; w++) begin
            push(W'(w));
            send_frame(W'(w), -1);
        end
        chk(urun_flag == 1'b0, "R10 no underrun when fed", urun_flag, 0);
        push(8'h5A);
        send_frame(8'h5A, 3);

        // R9: active edge without sync after the last bit holds the line
        one_tick();
        chk(sdo == 1'b0, "R9 hold after frame", sdo, 0);
        one_tick();
        chk(sdo == 1'b0, "R9 still waiting", sdo, 0);

        // R10: underrun replays the previous word
        send_frame(8'h5A, -1);
        chk(urun_flag == 1'b1, "R10 flag set", urun_flag, 1);
        push(8'h3C);
        send_frame(8'h3C, -1);
        chk(urun_flag == 1'b1, "R11 sticky", urun_flag, 1);
        urun_clr = 1'b1;
        wait_cyc(1);
        urun_clr = 1'b0;
        wait_cyc(1);
        chk(urun_flag == 1'b0, "R11 cleared", urun_flag, 0);

        // R13: one-entry staging, second offer refused
        push(8'h11);
        chk(word_ready == 1'b0, "R13 ready low when full", word_ready, 0);
        word_data  = 8'h22;
        word_valid = 1'b1;
        wait_cyc(1);
        word_valid = 1'b0;
        send_frame(8'h11, -1);
        chk(word_ready == 1'b1, "R13 ready after load", word_ready, 1);
        send_frame(8'h11, -1);
        chk(urun_flag == 1'b1, "R13 refused word not kept", urun_flag, 1);

        // R2: disable
        tx_en = 1'b0;
        wait_cyc(2);
        chk(sdo == 1'b0, "R2 low when disabled", sdo, 0);
        one_tick();
        chk(sdo == 1'b0, "R2 edges ignored when disabled", sdo, 0);
        urun_clr = 1'b1;
        wait_cyc(1);
        urun_clr = 1'b0;

        // LSB first, falling edges of the receive clock
        src_rcv   = 1'b1;
        fall_edge = 1'b1;
        lsb_first = 1'b1;
        wait_cyc(2);
        tx_en = 1'b1;
        wait_cyc(2);
        for (int w = 0; w < 256; w++) begin
            push(W'(255 - w));
            send_frame(W'(255 - w), (w == 77) ? 5 : -1);
        end
        chk(urun_flag == 1'b0, "R6 receive clock source fed", urun_flag, 0);

        // R7: divided receive clock, rising edges, MSB first
        tx_en = 1'b0;
        wait_cyc(2);
        div2_en   = 1'b1;
        fall_edge = 1'b0;
        lsb_first = 1'b0;
        wait_cyc(2);
        tx_en = 1'b1;
        wait_cyc(2);
        for (int k = 0; k < 24; k++) begin
            push(W'((k * 37 + 5) % 256));
            send_frame(W'((k * 37 + 5) % 256), (k == 3) ? 2 : -1);
        end
        fall_edge = 1'b1;
        tx_en = 1'b0;
        wait_cyc(2);
        tx_en = 1'b1;
        wait_cyc(2);
        for (int k = 0; k < 8; k++) begin
            push(W'(k * 29 + 1));
            send_frame(W'(k * 29 + 1), -1);
        end
        chk(urun_flag == 1'b0, "R7 divided clock fed", urun_flag, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule